// File: doc/BRIEF.md
# Interrupt Pin Trigger and Coalescing Engine

This block sits between the raw interrupt input pins and the message logic of an I/O interrupt controller. For every pin it holds a small trigger state machine that reads the pin level and the entry's configuration from the register block. That configuration is the polarity, the trigger mode, the mask, the vector and the destination. The state machine decides when the pin needs service. A lowest-index-first picker grants one pending pin per cycle. The grant is registered into a one-cycle delivery request that carries the pin number, the vector and the destination.

Level-triggered entries set a remote in-service flag when they are delivered. The flag stays set until an end-of-interrupt with the same vector arrives, or until the entry is switched to edge mode. While the flag is set, further activity on the line is coalesced. An end-of-interrupt that arrives while the line is still active causes the pin to be delivered again. Edge-triggered entries track the line even while masked, so unmasking never fires on a line that is already high. One configurable pin, the real-time-clock pin, also carries its own edge-coalescing flag. That flag absorbs repeated edges until its vector is acknowledged.

Each pin state machine has three states. IDLE goes to PEND on an unmasked rising active edge in edge mode, or on an unmasked active line in level mode. PEND goes to IDLE on a grant in edge mode, or to WAIT_EOI on a grant in level mode. A level-mode PEND falls back to IDLE if the line goes inactive or is masked before the grant. WAIT_EOI goes to IDLE on a matching end-of-interrupt, or when the entry leaves level mode.

Top module: `irq_trigger_core`

## Requirements
- R1: After reset `dlv_valid` is 0, every `remote_irr` bit is 0 and `rtc_coalesce` is 0.
- R2: A pin is active when `pin_level` XOR `cfg_polarity` is 1. In edge mode (`cfg_level` bit 0), an unmasked inactive-to-active change yields exactly one `dlv_valid` pulse. The pulse appears two clock edges after the change. It carries `dlv_pin` = the pin index, `dlv_vector` = that pin's 8-bit slice of `cfg_vector`, and `dlv_dest` = its 8-bit slice of `cfg_dest`. Holding the line active gives no further pulse.
- R3: In edge mode, every deassert-then-assert sequence yields a new delivery.
- R4: In edge mode, edges seen while masked (`cfg_mask` bit 1) never deliver, and unmasking a line that is already active does not deliver. The next rising edge after unmasking does deliver.
- R5: In level mode (`cfg_level` bit 1), an unmasked active line with `remote_irr` clear is delivered once, and `remote_irr` of that pin becomes 1. While it stays 1, line activity produces no delivery.
- R6: In level mode, a line that became active while masked is delivered once after it is unmasked.
- R7: An `eoi_valid` pulse whose `eoi_vector` equals a level entry's vector clears that entry's `remote_irr`. If the line is still active, the pin is delivered again. A non-matching vector changes nothing.
- R8: With `cfg_polarity` bit 1, a low pin level counts as active.
- R9: Masking and then unmasking a pin leaves its `remote_irr` bit unchanged.
- R10: The pin at index `RTC_PIN` (default 8), in edge mode, sets `rtc_coalesce` when it is delivered. Further rising edges are dropped until an end-of-interrupt that matches that pin's vector clears the flag.
- R11: Switching a level entry to edge mode clears its `remote_irr`. Switching it back to level mode while the line is active delivers again.
- R12: When several pins request in the same cycle, they are delivered in ascending pin order, one per cycle, and none is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | N_PINS | Raw interrupt input levels |
| cfg_polarity | input | N_PINS | 1: pin is active-low |
| cfg_level | input | N_PINS | 1: level-triggered, 0: edge-triggered |
| cfg_mask | input | N_PINS | 1: pin masked |
| cfg_vector | input | N_PINS*VEC_W | Per-pin vector, pin i in bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | N_PINS*DEST_W | Per-pin destination, pin i in bits [i*DEST_W +: DEST_W] |
| eoi_valid | input | 1 | End-of-interrupt notification strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| dlv_valid | output | 1 | One-cycle delivery request |
| dlv_pin | output | PIN_W | Index of the delivered pin |
| dlv_vector | output | VEC_W | Vector of the delivered pin |
| dlv_dest | output | DEST_W | Destination of the delivered pin |
| remote_irr | output | N_PINS | Per-pin remote in-service flag, for the register block |
| rtc_coalesce | output | 1 | Edge-coalescing flag of the real-time-clock pin |

## Verification
An end-of-interrupt that re-arms one level pin can land in the same cycle as fresh edges on several other pins. The re-armed pin then joins the priority race one cycle after the edge pins. To provoke this, pin 5 is delivered and left active. Then pins 2, 6 and 11 are raised in the same cycle that the end-of-interrupt for pin 5's vector is issued. The scoreboard expects the deliveries in the order 2, 5, 6, 11 on consecutive cycles. It flags any reordering, loss or extra pulse.

// File: rtl/irqtc_pkg.sv
package irqtc_pkg;
    typedef enum logic [1:0] {
        PS_IDLE     = 2'd0,
        PS_PEND     = 2'd1,
        PS_WAIT_EOI = 2'd2
    } pin_state_t;
endpackage

// File: rtl/irqtc_pin_fsm.sv
module irqtc_pin_fsm
    import irqtc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter bit IS_RTC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_in,
    input  logic             polarity,
    input  logic             level_mode,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             grant,
    output logic             req,
    output logic             irr,
    output logic             rtc_flag
);
    pin_state_t st_q, st_d;
    logic       prev_active_q;
    logic       active;
    logic       rise;
    logic       eoi_hit;
    logic       rtc_block;

    assign active  = level_in ^ polarity;
    assign rise    = active & ~prev_active_q;
    assign eoi_hit = eoi_valid & (eoi_vector == vector);

    generate
        if (IS_RTC) begin : g_rtc
            logic rtc_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rtc_q <= 1'b0;
                end else if (grant && !level_mode) begin
                    rtc_q <= 1'b1;
                end else if (eoi_hit) begin
                    rtc_q <= 1'b0;
                end
            end
            assign rtc_block = rtc_q;
        end else begin : g_plain
            assign rtc_block = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_IDLE: begin
                if (level_mode) begin
                    if (active && !mask) st_d = PS_PEND;
                end else if (rise && !mask && !rtc_block) begin
                    st_d = PS_PEND;
                end
            end
            PS_PEND: begin
                if (grant) begin
                    st_d = level_mode ? PS_WAIT_EOI : PS_IDLE;
                end else if (level_mode && (!active || mask)) begin
                    st_d = PS_IDLE;
                end
            end
            PS_WAIT_EOI: begin
                if (!level_mode || eoi_hit) st_d = PS_IDLE;
            end
            default: st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= PS_IDLE;
            prev_active_q <= 1'b0;
        end else begin
            st_q          <= st_d;
            prev_active_q <= active;
        end
    end

    always_comb begin
        req      = (st_q == PS_PEND) && !mask;
        irr      = (st_q == PS_WAIT_EOI);
        rtc_flag = rtc_block;
    end
endmodule

// File: rtl/irqtc_lowest_first.sv
module irqtc_lowest_first #(
    parameter int N_PINS = 24,
    localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic [N_PINS-1:0] req,
    output logic [N_PINS-1:0] grant,
    output logic [PIN_W-1:0]  grant_idx,
    output logic              grant_any
);
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = 0; i < N_PINS; i++) begin
            if (req[i] && !grant_any) begin
                grant[i]  = 1'b1;
                grant_idx = PIN_W'(i);
                grant_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqtc_launch_reg.sv
module irqtc_launch_reg #(
    parameter int N_PINS = 24,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grant_any,
    input  logic [PIN_W-1:0]         grant_idx,
    input  logic [N_PINS*VEC_W-1:0]  vec_flat,
    input  logic [N_PINS*DEST_W-1:0] dest_flat,
    output logic                     dlv_valid,
    output logic [PIN_W-1:0]         dlv_pin,
    output logic [VEC_W-1:0]         dlv_vector,
    output logic [DEST_W-1:0]        dlv_dest
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid  <= 1'b0;
            dlv_pin    <= '0;
            dlv_vector <= '0;
            dlv_dest   <= '0;
        end else begin
            dlv_valid <= grant_any;
            if (grant_any) begin
                dlv_pin    <= grant_idx;
                dlv_vector <= vec_flat[grant_idx*VEC_W +: VEC_W];
                dlv_dest   <= dest_flat[grant_idx*DEST_W +: DEST_W];
            end
        end
    end
endmodule

// File: rtl/irq_trigger_core.sv
module irq_trigger_core #(
    parameter int N_PINS  = 24,
    parameter int VEC_W   = 8,
    parameter int DEST_W  = 8,
    parameter int RTC_PIN = 8,
    localparam int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PINS-1:0]        pin_level,
    input  logic [N_PINS-1:0]        cfg_polarity,
    input  logic [N_PINS-1:0]        cfg_level,
    input  logic [N_PINS-1:0]        cfg_mask,
    input  logic [N_PINS*VEC_W-1:0]  cfg_vector,
    input  logic [N_PINS*DEST_W-1:0] cfg_dest,
    input  logic                     eoi_valid,
    input  logic [VEC_W-1:0]         eoi_vector,
    output logic                     dlv_valid,
    output logic [PIN_W-1:0]         dlv_pin,
    output logic [VEC_W-1:0]         dlv_vector,
    output logic [DEST_W-1:0]        dlv_dest,
    output logic [N_PINS-1:0]        remote_irr,
    output logic                     rtc_coalesce
);
    logic [N_PINS-1:0] pin_req;
    logic [N_PINS-1:0] pick_grant;
    logic [N_PINS-1:0] rtc_flags;
    logic [PIN_W-1:0]  pick_idx;
    logic              pick_any;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            irqtc_pin_fsm #(
                .VEC_W  (VEC_W),
                .IS_RTC (i == RTC_PIN)
            ) u_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .level_in   (pin_level[i]),
                .polarity   (cfg_polarity[i]),
                .level_mode (cfg_level[i]),
                .mask       (cfg_mask[i]),
                .vector     (cfg_vector[i*VEC_W +: VEC_W]),
                .eoi_valid  (eoi_valid),
                .eoi_vector (eoi_vector),
                .grant      (pick_grant[i]),
                .req        (pin_req[i]),
                .irr        (remote_irr[i]),
                .rtc_flag   (rtc_flags[i])
            );
        end
    endgenerate

    assign rtc_coalesce = |rtc_flags;

    irqtc_lowest_first #(.N_PINS(N_PINS)) u_pick (
        .req       (pin_req),
        .grant     (pick_grant),
        .grant_idx (pick_idx),
        .grant_any (pick_any)
    );

    irqtc_launch_reg #(
        .N_PINS (N_PINS),
        .VEC_W  (VEC_W),
        .DEST_W (DEST_W)
    ) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_any  (pick_any),
        .grant_idx  (pick_idx),
        .vec_flat   (cfg_vector),
        .dest_flat  (cfg_dest),
        .dlv_valid  (dlv_valid),
        .dlv_pin    (dlv_pin),
        .dlv_vector (dlv_vector),
        .dlv_dest   (dlv_dest)
    );
endmodule

// File: rtl/irq_trigger_core_chk.sv
module irq_trigger_core_chk #(
    parameter int N_PINS  = 24,
    parameter int RTC_PIN = 8,
    localparam int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] cfg_mask,
    input logic [N_PINS-1:0] cfg_level,
    input logic [N_PINS-1:0] grant,
    input logic              dlv_valid,
    input logic [PIN_W-1:0]  dlv_pin,
    input logic [N_PINS-1:0] remote_irr,
    input logic              rtc_coalesce
);
    logic [N_PINS-1:0] mask_q;
    logic [N_PINS-1:0] lvl_q;

    always_ff @(posedge clk) begin
        mask_q <= cfg_mask;
        lvl_q  <= cfg_level;
    end

    p_one_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("two pins granted at once");

    p_pin_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (int'(dlv_pin) < N_PINS)) else $error("delivery pin out of range");

    p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !mask_q[dlv_pin]) else $error("masked pin delivered");

    p_level_sets_irr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && lvl_q[dlv_pin]) |-> remote_irr[dlv_pin]) else $error("level delivery left irr clear");

    p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !(dlv_valid && dlv_pin == $past(dlv_pin))) else $error("same pin delivered twice in a row");

    p_rtc_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_pin == PIN_W'(RTC_PIN) && !lvl_q[RTC_PIN]) |-> rtc_coalesce)
        else $error("rtc delivery did not set flag");
endmodule

bind irq_trigger_core irq_trigger_core_chk #(
    .N_PINS  (N_PINS),
    .RTC_PIN (RTC_PIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mask     (cfg_mask),
    .cfg_level    (cfg_level),
    .grant        (pick_grant),
    .dlv_valid    (dlv_valid),
    .dlv_pin      (dlv_pin),
    .remote_irr   (remote_irr),
    .rtc_coalesce (rtc_coalesce)
);

// File: tb/tb_irq_trigger_core.sv
module tb_irq_trigger_core;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 24;
    localparam int PW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    pin_level = '0;
    logic [N-1:0]    cfg_polarity = '0;
    logic [N-1:0]    cfg_level = '0;
    logic [N-1:0]    cfg_mask = '0;
    logic [N*8-1:0]  cfg_vector;
    logic [N*8-1:0]  cfg_dest;
    logic            eoi_valid = 1'b0;
    logic [7:0]      eoi_vector = '0;
    logic            dlv_valid;
    logic [PW-1:0]   dlv_pin;
    logic [7:0]      dlv_vector;
    logic [7:0]      dlv_dest;
    logic [N-1:0]    remote_irr;
    logic            rtc_coalesce;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_trigger_core dut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
        .cfg_polarity(cfg_polarity), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
        .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
        .dlv_dest(dlv_dest), .remote_irr(remote_irr), .rtc_coalesce(rtc_coalesce)
    );

    function automatic logic [23:0] item(int p);
        return {8'(p), 8'(8'h20 + p), 8'(8'h40 + p)};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_dlv(int p, string tag);
        exp_q.push_back(item(p));
        tag_q.push_back(tag);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(string tag);
        chk(exp_q.size() == 0, tag, "missing deliveries", 0, exp_q.size());
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic send_eoi(int v);
        eoi_valid  = 1'b1;
        eoi_vector = 8'(v);
        @(negedge clk);
        eoi_valid  = 1'b0;
    endtask

    // monitor: pops the scoreboard on every delivery
    always @(negedge clk) begin
        if (rst_n && dlv_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3/R4/R5/R10", "unexpected delivery", int'({8'(dlv_pin), dlv_vector, dlv_dest}), 0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({8'(dlv_pin), dlv_vector, dlv_dest} == e, t, "delivery",
                    int'({8'(dlv_pin), dlv_vector, dlv_dest}), int'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_vector[i*8 +: 8] = 8'(8'h20 + i);
            cfg_dest[i*8 +: 8]   = 8'(8'h40 + i);
        end
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1
        chk(dlv_valid == 1'b0, "R1", "dlv_valid", dlv_valid, 0);
        chk(remote_irr == '0, "R1", "remote_irr", remote_irr, 0);
        chk(rtc_coalesce == 1'b0, "R1", "rtc_coalesce", rtc_coalesce, 0);

        // R2: single delivery, held line gives no more
        pin_level[23] = 1'b1; expect_dlv(23, "R2");
        step(5); step(5);
        drained("R2");

        // R3: each deassert/assert delivers
        pin_level[23] = 1'b0; step(2);
        pin_level[23] = 1'b1; expect_dlv(23, "R3"); step(4);
        pin_level[23] = 1'b0; step(2);
        pin_level[23] = 1'b1; expect_dlv(23, "R3"); step(4);
        drained("R3");

        // R4: masked edges tracked, unmask while high silent
        cfg_mask[23] = 1'b1;
        pin_level[23] = 1'b0; step(2);
        pin_level[23] = 1'b1; step(2);
        pin_level[23] = 1'b0; step(2);
        pin_level[23] = 1'b1; step(2);
        cfg_mask[23] = 1'b0; step(4);
        drained("R4");
        pin_level[23] = 1'b0; step(2);
        pin_level[23] = 1'b1; expect_dlv(23, "R4"); step(4);
        drained("R4");
        pin_level[23] = 1'b0;

        // R5: level delivery sets irr, further activity coalesced
        cfg_level[5] = 1'b1;
        pin_level[5] = 1'b1; expect_dlv(5, "R5"); step(4);
        chk(remote_irr[5] == 1'b1, "R5", "irr after level delivery", remote_irr[5], 1);
        pin_level[5] = 1'b0; step(2);
        pin_level[5] = 1'b1; step(4);
        drained("R5");

        // R9: mask/unmask keeps irr
        cfg_mask[5] = 1'b1; step(2);
        cfg_mask[5] = 1'b0; step(2);
        chk(remote_irr[5] == 1'b1, "R9", "irr after mask cycle", remote_irr[5], 1);
        drained("R9");

        // R7: wrong vector no effect, matching vector reinjects
        send_eoi(8'h26); step(3);
        chk(remote_irr[5] == 1'b1, "R7", "irr after wrong eoi", remote_irr[5], 1);
        drained("R7");
        expect_dlv(5, "R7");
        send_eoi(8'h25); step(5);
        chk(remote_irr[5] == 1'b1, "R7", "irr after reinjection", remote_irr[5], 1);
        drained("R7");
        pin_level[5] = 1'b0;
        send_eoi(8'h25); step(3);
        chk(remote_irr[5] == 1'b0, "R7", "irr after eoi, line low", remote_irr[5], 0);
        drained("R7");

        // R6: active while masked fires on unmask
        cfg_mask[5] = 1'b1; pin_level[5] = 1'b1; step(4);
        drained("R6");
        cfg_mask[5] = 1'b0; expect_dlv(5, "R6"); step(4);
        drained("R6");

        // R11: level->edge clears irr, back to level redelivers
        cfg_level[5] = 1'b0; step(2);
        chk(remote_irr[5] == 1'b0, "R11", "irr after switch to edge", remote_irr[5], 0);
        cfg_level[5] = 1'b1; expect_dlv(5, "R11"); step(4);
        drained("R11");
        chk(remote_irr[5] == 1'b1, "R11", "irr after switch back", remote_irr[5], 1);
        pin_level[5] = 1'b0;
        send_eoi(8'h25); step(2);

        // R8: active-low line
        cfg_mask[3] = 1'b1; pin_level[3] = 1'b1; step(2);
        cfg_polarity[3] = 1'b1; cfg_level[3] = 1'b1; step(2);
        cfg_mask[3] = 1'b0; step(3);
        drained("R8");
        pin_level[3] = 1'b0; expect_dlv(3, "R8"); step(4);
        chk(remote_irr[3] == 1'b1, "R8", "irr on low-active delivery", remote_irr[3], 1);
        drained("R8");
        pin_level[3] = 1'b1;
        send_eoi(8'h23); step(3);
        chk(remote_irr[3] == 1'b0, "R8", "irr after eoi", remote_irr[3], 0);

        // R10: rtc pin coalescing
        pin_level[8] = 1'b1; expect_dlv(8, "R10"); step(4);
        chk(rtc_coalesce == 1'b1, "R10", "rtc flag set", rtc_coalesce, 1);
        pin_level[8] = 1'b0; step(2);
        pin_level[8] = 1'b1; step(4);
        drained("R10");
        pin_level[8] = 1'b0;
        send_eoi(8'h28); step(3);
        chk(rtc_coalesce == 1'b0, "R10", "rtc flag cleared", rtc_coalesce, 0);
        pin_level[8] = 1'b1; expect_dlv(8, "R10"); step(4);
        drained("R10");
        pin_level[8] = 1'b0;
        send_eoi(8'h28); step(2);

        // R12: simultaneous edges plus eoi re-arming a level pin
        pin_level[5] = 1'b1; expect_dlv(5, "R12"); step(4);
        drained("R12");
        pin_level[2] = 1'b1; pin_level[6] = 1'b1; pin_level[11] = 1'b1;
        expect_dlv(2, "R12"); expect_dlv(5, "R12");
        expect_dlv(6, "R12"); expect_dlv(11, "R12");
        send_eoi(8'h25); step(6);
        drained("R12");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule